// File: doc/BRIEF.md
# SPI Controller Status and Interrupt Unit

This unit is the register front end and status engine of a memory-mapped SPI master controller. It decodes 32-bit word accesses, passes transmit words into an external transmit FIFO, pops words from an external receive FIFO, and builds a live status word from the flags of both FIFOs. Two of the status bits are sticky event flags, receive overflow and transfer done, which software clears by writing 1 to them. A single level interrupt is raised whenever any status bit and its enable bit are both set.

The FIFOs and the serial shifting engine live outside this unit. The unit sees their empty and full flags, the head word of the receive FIFO, a pulse for each word arriving into the receive FIFO, and a pulse when a transfer completes. Writing the control register with its enable bit at 0 resets the whole controller. The unit clears its own control, enable-mask and sticky state, and pulses `fifo_clear` so that both FIFOs are flushed.

Top module: `spi_stat_irq`

## Requirements
- R1: The status word sits at byte offset 0x10. It is built live from the FIFO flags: bit 0 = transmit FIFO empty, bit 1 = transmit FIFO full, bit 3 = receive FIFO not empty, bit 4 = receive FIFO full. After reset, with both FIFOs empty, it reads 0x00000001.
- R2: Status bit 6 (overflow) is set when `rx_arrive` pulses while `rx_full` is 1. It stays set until it is cleared.
- R3: Status bit 7 (done) is set by a `xfer_done` pulse. It stays set until it is cleared.
- R4: Writing the status word clears bit 6 and/or bit 7 where the written data has a 1. Every other status bit ignores the write.
- R5: `irq` is a register that is 1 one cycle after any status bit and its matching bit of the interrupt-enable word (byte offset 0x0C) are both 1. With the enable word at 0, `irq` is 0.
- R6: The control word is at byte offset 0x08, and bit 0 is the enable. A control write with bit 0 = 0 leaves control, interrupt enable, overflow and done all at 0, and pulses `fifo_clear` during that write cycle.
- R7: A read of byte offset 0x00 while enabled and with the receive FIFO not empty pulses `rx_pop` and returns `rx_head`. Otherwise it returns 0 without a pop. Read data appears on `bus_rdata` on the clock edge that samples `bus_rd`.
- R8: A write to byte offset 0x04 pulses `tx_push` with `tx_data` = write data, but only while enabled and with the transmit FIFO not full. Otherwise the write is dropped. Reads of offsets 0x04 and 0x14 return 0.
- R9: The register index is the byte offset shifted right by 2. Writes to offset 0x00, accesses with nonzero offset bits [1:0], and indices above 5 are ignored: their reads return 0 and their writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, registered |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_full | input | 1 | Transmit FIFO full |
| tx_push | output | 1 | Push strobe to transmit FIFO |
| tx_data | output | DW | Word pushed to transmit FIFO |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_full | input | 1 | Receive FIFO full |
| rx_head | input | DW | Head word of receive FIFO |
| rx_pop | output | 1 | Pop strobe to receive FIFO |
| rx_arrive | input | 1 | A received word is offered to the receive FIFO |
| xfer_done | input | 1 | Transfer completion pulse |
| fifo_clear | output | 1 | Flush both FIFOs (controller reset) |
| ctrl | output | DW | Current control word |
| irq | output | 1 | Level interrupt |

## Verification
`tx_push`, `rx_pop` and `fifo_clear` are combinational in the access cycle, so the bench counts them on the edge that ends that cycle. Read data is due on the edge that samples `bus_rd`. The scoreboard pairs each read with the first falling edge after that edge. Sticky flags settle one edge after their event pulse. `irq` settles one edge later still, so every interrupt check waits one full cycle after the status or mask change has been registered.

// File: rtl/spi_stat_irq.sv
module spi_stat_irq #(
  parameter int ADDR_W = 12,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              tx_empty,
  input  logic              tx_full,
  output logic              tx_push,
  output logic [DW-1:0]     tx_data,
  input  logic              rx_empty,
  input  logic              rx_full,
  input  logic [DW-1:0]     rx_head,
  output logic              rx_pop,
  input  logic              rx_arrive,
  input  logic              xfer_done,
  output logic              fifo_clear,
  output logic [DW-1:0]     ctrl,
  output logic              irq
);
  localparam int IW = ADDR_W - 2;
  localparam logic [IW-1:0] I_RX   = IW'(0);
  localparam logic [IW-1:0] I_TX   = IW'(1);
  localparam logic [IW-1:0] I_CTRL = IW'(2);
  localparam logic [IW-1:0] I_IEN  = IW'(3);
  localparam logic [IW-1:0] I_STAT = IW'(4);
  localparam int B_OVF  = 6;
  localparam int B_DONE = 7;

  logic [DW-1:0] ctrl_q, ien_q, status, rd_mux;
  logic          ovf_q, done_q;

  wire [IW-1:0] idx     = bus_addr[ADDR_W-1:2];
  wire          aligned = (bus_addr[1:0] == 2'b00);
  wire          wr_ok   = bus_wr && aligned;
  wire          en      = ctrl_q[0];
  wire          wr_ctrl = wr_ok && (idx == I_CTRL);
  wire          wr_ien  = wr_ok && (idx == I_IEN);
  wire          wr_stat = wr_ok && (idx == I_STAT);

  assign fifo_clear = wr_ctrl && !bus_wdata[0];
  assign tx_push    = wr_ok && (idx == I_TX) && en && !tx_full;
  assign tx_data    = bus_wdata;
  assign rx_pop     = bus_rd && aligned && (idx == I_RX) && en && !rx_empty;
  assign ctrl       = ctrl_q;

  always_comb begin
    status         = '0;
    status[0]      = tx_empty;
    status[1]      = tx_full;
    status[3]      = !rx_empty;
    status[4]      = rx_full;
    status[B_OVF]  = ovf_q;
    status[B_DONE] = done_q;
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      case (idx)
        I_RX:    rd_mux = rx_pop ? rx_head : '0;
        I_CTRL:  rd_mux = ctrl_q;
        I_IEN:   rd_mux = ien_q;
        I_STAT:  rd_mux = status;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      ien_q     <= '0;
      ovf_q     <= 1'b0;
      done_q    <= 1'b0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (fifo_clear) begin
        ctrl_q <= '0;
        ien_q  <= '0;
        ovf_q  <= 1'b0;
        done_q <= 1'b0;
      end else begin
        if (wr_ctrl) ctrl_q <= bus_wdata;
        if (wr_ien)  ien_q  <= bus_wdata;
        ovf_q  <= (rx_arrive && rx_full) || (ovf_q && !(wr_stat && bus_wdata[B_OVF]));
        done_q <= xfer_done || (done_q && !(wr_stat && bus_wdata[B_DONE]));
      end
      irq <= |(status & ien_q);
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

module spi_stat_irq_chk #(
  parameter int ADDR_W = 12,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              tx_full,
  input logic              rx_empty,
  input logic              rx_full,
  input logic              rx_arrive,
  input logic              tx_push,
  input logic              rx_pop,
  input logic [DW-1:0]     ctrl_q,
  input logic [DW-1:0]     ien_q,
  input logic              ovf_q,
  input logic              irq
);
  wire kill_wr = bus_wr && (bus_addr == ADDR_W'(8)) && !bus_wdata[0];

  AST_PUSH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> (ctrl_q[0] && !tx_full)); // R8
  AST_POP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> (ctrl_q[0] && !rx_empty)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !bus_wr) |=> ovf_q); // R2
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_arrive && rx_full && !bus_wr) |=> ovf_q); // R2
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |=> !irq); // R5
  AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kill_wr |=> (ctrl_q == '0 && ien_q == '0 && !ovf_q)); // R6
endmodule

bind spi_stat_irq spi_stat_irq_chk #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .tx_full(tx_full), .rx_empty(rx_empty),
  .rx_full(rx_full), .rx_arrive(rx_arrive), .tx_push(tx_push),
  .rx_pop(rx_pop), .ctrl_q(ctrl_q), .ien_q(ien_q), .ovf_q(ovf_q), .irq(irq)
);

// File: tb/test_spi_stat_irq.sv
module test_spi_stat_irq;
  localparam int CLK_NS = 10;
  localparam int AW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, tx_data, rx_head = '0, ctrl;
  logic tx_empty = 1, tx_full = 0, rx_empty = 1, rx_full = 0;
  logic rx_arrive = 0, xfer_done = 0;
  logic tx_push, rx_pop, fifo_clear, irq;

  int checks = 0, errors = 0;
  int pushes = 0, pops = 0, clears = 0;
  logic [31:0] last_tx = '0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 0;

  spi_stat_irq #(.ADDR_W(AW), .DW(32)) i_spi_stat_irq (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_empty(tx_empty), .tx_full(tx_full), .tx_push(tx_push), .tx_data(tx_data),
    .rx_empty(rx_empty), .rx_full(rx_full), .rx_head(rx_head), .rx_pop(rx_pop),
    .rx_arrive(rx_arrive), .xfer_done(xfer_done), .fifo_clear(fifo_clear),
    .ctrl(ctrl), .irq(irq));

  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) begin
    rd_seen <= bus_rd;
    if (tx_push) begin pushes <= pushes + 1; last_tx <= tx_data; end
    if (rx_pop) pops <= pops + 1;
    if (fifo_clear) clears <= clears + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("scoreboard underrun", 32'd1, 32'd0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    bus_rd = 1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic pulse_arrive();
    rx_arrive = 1; @(negedge clk); rx_arrive = 0;
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    check("R5 irq after reset", {31'd0, irq}, 32'd0);
    rd(12'h010, 32'h01, "R1 status after reset");
    wr(12'h008, 32'h1);
    rd(12'h008, 32'h1, "R6 control readback");
    wr(12'h004, 32'hA5);
    check("R8 push count", pushes, 1);
    check("R8 pushed word", last_tx, 32'hA5);
    tx_empty = 0; tx_full = 1;
    wr(12'h004, 32'h77);
    check("R8 full drops write", pushes, 1);
    rd(12'h010, 32'h02, "R1 tx full status");
    rx_empty = 0; rx_head = 32'h1234ABCD;
    rd(12'h010, 32'h0A, "R1 rx not empty status");
    rd(12'h000, 32'h1234ABCD, "R7 rx port pop data");
    check("R7 pop count", pops, 1);
    rx_empty = 1;
    rd(12'h000, 32'h0, "R7 empty read returns 0");
    check("R7 no pop when empty", pops, 1);
    rd(12'h004, 32'h0, "R8 tx port reads 0");
    rd(12'h014, 32'h0, "R8 msg port reads 0");
    rd(12'h011, 32'h0, "R9 misaligned read");
    rd(12'h020, 32'h0, "R9 out of range read");
    rx_empty = 0;
    wr(12'h000, 32'hFFFF);
    wr(12'h00B, 32'h0);
    check("R9 rx port write no pop", pops, 1);
    check("R9 misaligned ctrl write ignored", ctrl, 32'h1);
    rx_full = 1;
    pulse_arrive();
    rd(12'h010, 32'h5A, "R2 overflow set");
    wr(12'h010, 32'h1B);
    rd(12'h010, 32'h5A, "R4 other bits ignore write");
    wr(12'h010, 32'h40);
    rd(12'h010, 32'h1A, "R4 overflow cleared");
    xfer_done = 1; tick(1); xfer_done = 0;
    rd(12'h010, 32'h9A, "R3 done set");
    tick(2);
    rd(12'h010, 32'h9A, "R3 done sticky");
    check("R5 irq masked", {31'd0, irq}, 32'd0);
    wr(12'h00C, 32'h80);
    tick(1);
    check("R5 irq on done", {31'd0, irq}, 32'd1);
    wr(12'h010, 32'h80);
    tick(1);
    check("R5 irq drops after clear", {31'd0, irq}, 32'd0);
    wr(12'h00C, 32'h08);
    tick(1);
    check("R5 irq on rx ready", {31'd0, irq}, 32'd1);
    rx_empty = 1; rx_full = 0;
    tick(2);
    check("R5 irq follows live flag", {31'd0, irq}, 32'd0);
    rx_full = 1; pulse_arrive(); rx_full = 0;
    wr(12'h008, 32'h0);
    check("R6 fifo clear pulse", clears, 1);
    rd(12'h008, 32'h0, "R6 control cleared");
    rd(12'h00C, 32'h0, "R6 enable mask cleared");
    rd(12'h010, 32'h02, "R6 overflow cleared");
    tx_full = 0;
    wr(12'h004, 32'h55);
    check("R8 disabled drops write", pushes, 1);
    rx_empty = 0;
    rd(12'h000, 32'h0, "R7 disabled read returns 0");
    check("R7 disabled no pop", pops, 1);
    tick(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule